// File: doc/BRIEF.md
# Edge-Triggered Capture and Transition Counter

This block is one timer input-capture channel. A host configures it through a small register interface and then starts it with a service command. The block synchronizes an input pin and watches it for the configured edge type. On every qualifying edge it takes a 16-bit sample and advances a transition counter by one. The sample comes from one of two free-running timebases, latched in the cycle the edge is seen. In the other capture mode it is a word from a local parameter array, read when the edge is serviced.

Each time the counter reaches the programmed maximum, the sample is stored in a separate final-capture register and a sticky interrupt is raised. If links are enabled, a one-cycle request pulse also goes to a contiguous, wrapping group of up to eight other channels. In continuous mode the counter then restarts from zero. In single-shot mode edge detection stops until the next initialization.

Register map (5-bit address): 0 control (bits [1:0] edge type, bit 2 timebase select, 9 bits stored); 1 link/parameter word (bits [3:0] parameter index, [7:4] kept, [11:8] link count, [15:12] first linked channel); 2 maximum count; 3 transition count (read only); 4 final capture (read only); 5 last capture (read only); 6 command (write bits [1:0] service command, bits [3:2] sequence bits; read returns the sequence bits in [3:2]); 7 status (bit 0 interrupt flag, write 1 to clear; bit 1 detection armed); 16 to 31 parameter words 0 to 15.

Top module: `edge_capture_counter`

## Requirements
- R1: Writing command value 01 to address 6 initializes in timebase-capture mode and value 10 initializes in parameter-capture mode; values 00 and 11 change neither the counter nor the armed state, though bits [3:2] of the write always update the sequence bits.
- R2: Initialization clears the transition counter to zero, sets the armed flag and discards an edge that is waiting for service; after reset the counter, captures, status and link outputs are zero and detection is disarmed.
- R3: Control bits [1:0] choose the edge type: 00 none, 01 rising, 10 falling, 11 both; control bit 2 selects timebase B (1) or timebase A (0).
- R4: Each detected edge adds exactly one to the transition counter; the counter shows the new value four clock cycles after the pin changes, two cycles of that being the pin synchronizer.
- R5: When the incremented count differs from the maximum, the sample is written to the last-capture register and the final-capture register keeps its value.
- R6: When the incremented count equals the maximum, the sample is written to the final-capture register only, and the interrupt flag (status bit 0 and the irq output) is set; writing 1 to status bit 0 clears it.
- R7: In timebase-capture mode the timebase is latched in the cycle the edge is detected, so later timebase changes do not alter that sample; in parameter-capture mode the sample is the parameter word indexed by bits [3:0] of address 1.
- R8: When sequence bit 1 is set and the count completes, link_req carries a one-cycle pulse with bits (first + i) mod 16 set for i below the link count; a link count above 8 acts as 8 and a count of 0 sends no pulse.
- R9: When sequence bit 0 is set, completion returns the counter to zero and detection continues; when it is clear, the counter holds the maximum and all later edges are ignored until initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous input pin being watched |
| tb_a | input | 16 | Free-running timebase A |
| tb_b | input | 16 | Free-running timebase B |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 5 | Register address |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for host_addr |
| irq | output | 1 | Sticky completion interrupt |
| link_req | output | 16 | One-cycle link request pulse, one bit per channel |

## Verification
The assertions assume that the host never issues an initialization in the same cycle that it expects a service to land. Where the two coincide, initialization wins and the service checks are written to exclude that cycle. They also take pin edges to be at least one clock apart after synchronization, which any pin waveform satisfies. The bench drives the pin and host writes only on falling clock edges. It waits six cycles between pin toggles so each edge is serviced alone. The one deliberate overlap, initialization colliding with a pending edge, is timed to the exact service cycle.

// File: rtl/ecc_pkg.sv
// Package: shared constants and command encoding for the capture counter.
// Assumes a 5-bit host address space with the parameter array in the upper half.
package ecc_pkg;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int CHANNELS   = 16;
    localparam int LINK_MAX   = 8;
    localparam int PARAM_DEPTH = 16;

    typedef enum logic [1:0] {
        CMD_IDLE     = 2'b00,
        CMD_INIT_TB  = 2'b01,
        CMD_INIT_PRM = 2'b10,
        CMD_IDLE_HI  = 2'b11
    } svc_cmd_e;

    localparam logic [ADDR_W-1:0] RA_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] RA_LINK  = 5'd1;
    localparam logic [ADDR_W-1:0] RA_MAX   = 5'd2;
    localparam logic [ADDR_W-1:0] RA_COUNT = 5'd3;
    localparam logic [ADDR_W-1:0] RA_FINAL = 5'd4;
    localparam logic [ADDR_W-1:0] RA_LAST  = 5'd5;
    localparam logic [ADDR_W-1:0] RA_CMD   = 5'd6;
    localparam logic [ADDR_W-1:0] RA_STAT  = 5'd7;
endpackage

// File: rtl/ecc_edge_detect.sv
// Module: two-flop pin synchronizer followed by a selectable edge detector.
// Assumes pin_in is asynchronous; edge_o is combinational from registered state.
module ecc_edge_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [1:0] sel,
    output logic       edge_o
);
    logic s1, s2, prev;

    // Purpose: bring the pin into the clock domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pin_in;
            s2   <= s1;
            prev <= s2;
        end
    end

    // Purpose: qualify rising and falling transitions against the selection.
    always_comb begin
        edge_o = (sel[0] & s2 & ~prev) | (sel[1] & ~s2 & prev);
    end

    a_r3_no_edge_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |-> !edge_o);
endmodule

// File: rtl/ecc_link_gen.sv
// Module: builds a wrapping one-bit-per-channel link request pulse.
// Assumes CHANNELS is a power of two so channel arithmetic wraps naturally.
module ecc_link_gen #(
    parameter int CHANNELS = 16,
    parameter int LINK_MAX = 8,
    localparam int CH_W    = $clog2(CHANNELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic [CH_W-1:0]     first_ch,
    input  logic [CH_W-1:0]     ch_count,
    output logic [CHANNELS-1:0] link_req
);
    logic [CH_W-1:0]     eff_count;
    logic [CHANNELS-1:0] mask;

    // Purpose: clamp the requested group size to the supported maximum.
    always_comb begin
        eff_count = (ch_count > CH_W'(LINK_MAX)) ? CH_W'(LINK_MAX) : ch_count;
    end

    genvar j;
    generate
        for (j = 0; j < CHANNELS; j++) begin : g_ch
            logic [CH_W-1:0] offs;
            // Purpose: a channel belongs to the group if its wrapped offset is in range.
            always_comb begin
                offs    = CH_W'(j) - first_ch;
                mask[j] = (offs < eff_count);
            end
        end
    endgenerate

    // Purpose: emit the group mask for exactly one cycle per completion.
    always_ff @(posedge clk) begin
        if (!rst_n) link_req <= '0;
        else        link_req <= fire ? mask : '0;
    end

    a_r8_link_group_size: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(link_req) <= LINK_MAX);
    a_r8_link_from_completion: assert property (@(posedge clk) disable iff (!rst_n)
        (|link_req) |-> $past(fire));
endmodule

// File: rtl/edge_capture_counter.sv
// Module: input-capture channel with transition counting, final capture,
// interrupt and link generation. Holds the host registers and parameter array.
// Assumes host writes are single-cycle strobes; reads are combinational.
module edge_capture_counter
    import ecc_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int AW      = ADDR_W,
    parameter int NCH     = CHANNELS,
    parameter int NLINK   = LINK_MAX,
    parameter int PDEPTH  = PARAM_DEPTH,
    localparam int PIDX_W = $clog2(PDEPTH),
    localparam int CH_W   = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_in,
    input  logic [DW-1:0] tb_a,
    input  logic [DW-1:0] tb_b,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          irq,
    output logic [NCH-1:0] link_req
);
    logic [8:0]    ctrl_q;
    logic [DW-1:0] link_q, max_q, cnt_q, final_q, last_q, cap_q;
    logic [1:0]    seq_q;
    logic          armed_q, pend_q, pmode_q, irq_q;
    logic [DW-1:0] param_q [PDEPTH];

    logic          edge_raw, edge_q, init_cmd, hit, stop, wr_cmd, wr_stat;
    logic [DW-1:0] cnt_inc, sample;
    svc_cmd_e      cmd;

    ecc_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .sel(ctrl_q[1:0]), .edge_o(edge_raw)
    );

    ecc_link_gen #(.CHANNELS(NCH), .LINK_MAX(NLINK)) u_link (
        .clk(clk), .rst_n(rst_n), .fire(hit && seq_q[1] && !init_cmd),
        .first_ch(link_q[15:12]), .ch_count(link_q[11:8]), .link_req(link_req)
    );

    // Purpose: decode host strobes and the service-path arithmetic.
    always_comb begin
        wr_cmd   = host_wr && (host_addr == RA_CMD);
        wr_stat  = host_wr && (host_addr == RA_STAT);
        cmd      = svc_cmd_e'(host_wdata[1:0]);
        init_cmd = wr_cmd && (cmd == CMD_INIT_TB || cmd == CMD_INIT_PRM);
        edge_q   = edge_raw && armed_q;
        cnt_inc  = cnt_q + 1'b1;
        sample   = pmode_q ? param_q[link_q[PIDX_W-1:0]] : cap_q;
        hit      = pend_q && (cnt_inc == max_q);
        stop     = hit && !seq_q[0];
    end

    // Purpose: host-writable configuration and the parameter array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            link_q <= '0;
            max_q  <= '0;
            seq_q  <= '0;
            for (int i = 0; i < PDEPTH; i++) param_q[i] <= '0;
        end else if (host_wr) begin
            if (host_addr == RA_CTRL) ctrl_q <= host_wdata[8:0];
            if (host_addr == RA_LINK) link_q <= host_wdata;
            if (host_addr == RA_MAX)  max_q  <= host_wdata;
            if (wr_cmd)               seq_q  <= host_wdata[3:2];
            if (host_addr[AW-1])      param_q[host_addr[PIDX_W-1:0]] <= host_wdata;
        end
    end

    // Purpose: edge capture, transition counting and completion handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            final_q <= '0;
            last_q  <= '0;
            cap_q   <= '0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            pmode_q <= 1'b0;
        end else if (init_cmd) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            pend_q  <= 1'b0;
            pmode_q <= (cmd == CMD_INIT_PRM);
        end else begin
            pend_q <= edge_q && !stop;
            if (edge_q) cap_q <= ctrl_q[2] ? tb_b : tb_a;
            if (pend_q) begin
                if (hit) begin
                    final_q <= sample;
                    cnt_q   <= seq_q[0] ? '0 : cnt_inc;
                    if (stop) armed_q <= 1'b0;
                end else begin
                    last_q <= sample;
                    cnt_q  <= cnt_inc;
                end
            end
        end
    end

    // Purpose: sticky interrupt, set on completion, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                        irq_q <= 1'b0;
        else if (hit && !init_cmd)         irq_q <= 1'b1;
        else if (wr_stat && host_wdata[0]) irq_q <= 1'b0;
    end

    assign irq = irq_q;

    // Purpose: host read multiplexer.
    always_comb begin
        host_rdata = '0;
        if (host_addr[AW-1]) host_rdata = param_q[host_addr[PIDX_W-1:0]];
        else begin
            case (host_addr)
                RA_CTRL:  host_rdata = {{(DW-9){1'b0}}, ctrl_q};
                RA_LINK:  host_rdata = link_q;
                RA_MAX:   host_rdata = max_q;
                RA_COUNT: host_rdata = cnt_q;
                RA_FINAL: host_rdata = final_q;
                RA_LAST:  host_rdata = last_q;
                RA_CMD:   host_rdata = {{(DW-4){1'b0}}, seq_q, 2'b00};
                RA_STAT:  host_rdata = {{(DW-2){1'b0}}, armed_q, irq_q};
                default:  host_rdata = '0;
            endcase
        end
    end

    a_r4_count_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !hit && !init_cmd) |=> ((cnt_q - $past(cnt_q)) == DW'(1)));
    a_r5_final_holds_midcount: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !hit && !init_cmd) |=> $stable(final_q));
    a_r6_last_holds_on_final: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !init_cmd) |=> ($stable(last_q) && irq));
    a_r9_single_shot_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !pend_q && !init_cmd) |=> $stable(cnt_q));
    a_r9_continuous_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && seq_q[0] && !init_cmd) |=> (cnt_q == '0 && armed_q));
    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_cmd |=> (cnt_q == '0 && armed_q && !pend_q));
    // Unused bits of the link word beyond the parameter index are kept for readback.
endmodule

// File: tb/edge_capture_counter_test.sv
`timescale 1ns/1ps
module edge_capture_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] tb_a = '0, tb_b = '0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq;
    logic [15:0] link_req;

    int n_checks = 0, n_fail = 0;
    int link_pulses = 0;
    logic [15:0] link_seen = '0;

    edge_capture_counter uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tb_a(tb_a), .tb_b(tb_b),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq), .link_req(link_req)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (link_req != 16'h0) begin
            link_pulses++;
            link_seen = link_req;
        end
    end

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish (got hang, expected completion)");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        host_addr = a; #0.1; d = host_rdata;
    endtask

    task automatic toggle(input logic [15:0] va, input logic [15:0] vb);
        tb_a = va; tb_b = vb; pin_in = ~pin_in;
        repeat (6) @(negedge clk);
    endtask

    logic [15:0] r;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        rd(5'd3, r); chk("R2 reset count", r, 16'h0);
        rd(5'd7, r); chk("R2 reset status", r, 16'h0);
        chk("R2 reset link", link_req, 16'h0);

        // R4 / R7: latency and timebase latching
        wr(5'd0, 16'h0003); wr(5'd2, 16'd100); wr(5'd6, 16'h0005);
        tb_a = 16'h1111; pin_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(5'd3, r); chk("R4 count before service", r, 16'h0);
        tb_a = 16'h2222;
        @(posedge clk); @(negedge clk);
        rd(5'd3, r); chk("R4 count after four cycles", r, 16'h1);
        rd(5'd5, r); chk("R7 timebase latched at edge", r, 16'h1111);
        repeat (4) @(negedge clk);

        // R5 R6 R8 R9: sweep of maximum and sequence bits
        for (int mx = 1; mx <= 3; mx++) begin
            for (int sq = 0; sq < 4; sq++) begin
                int ecnt, comps;
                logic [15:0] elast, efin;
                logic armed;
                wr(5'd1, 16'hE300); wr(5'd2, 16'(mx));
                rd(5'd4, efin); rd(5'd5, elast);
                wr(5'd6, 16'((sq << 2) | 1));
                wr(5'd7, 16'h0001);
                link_pulses = 0; link_seen = '0;
                ecnt = 0; comps = 0; armed = 1'b1;
                for (int i = 0; i < 2 * mx + 1; i++) begin
                    logic [15:0] v;
                    v = 16'(mx * 256 + sq * 16 + i);
                    toggle(v, 16'h0);
                    if (armed) begin
                        if (ecnt + 1 == mx) begin
                            efin = v; comps++;
                            if (sq[0]) ecnt = 0; else begin ecnt = ecnt + 1; armed = 1'b0; end
                        end else begin
                            elast = v; ecnt = ecnt + 1;
                        end
                    end
                end
                rd(5'd3, r); chk("R9 count after sweep", r, 16'(ecnt));
                rd(5'd5, r); chk("R5 last capture", r, elast);
                rd(5'd4, r); chk("R6 final capture", r, efin);
                chk("R6 irq raised", {15'h0, irq}, 16'h1);
                rd(5'd7, r); chk("R9 armed state", {15'h0, r[1]}, {15'h0, armed});
                chk("R8 link pulse count", 16'(link_pulses), sq[1] ? 16'(comps) : 16'h0);
                chk("R8 link mask wraps", link_seen, sq[1] ? 16'hC001 : 16'h0);
            end
        end

        // R6: write 1 clears interrupt
        wr(5'd7, 16'h0001);
        chk("R6 irq cleared", {15'h0, irq}, 16'h0);

        // R3: edge selection sweep
        for (int s = 0; s < 4; s++) begin
            int exp_n;
            exp_n = 0;
            wr(5'd0, 16'(s)); wr(5'd2, 16'd1000); wr(5'd6, 16'h0005);
            for (int i = 0; i < 6; i++) begin
                logic lvl;
                lvl = pin_in;
                toggle(16'h0, 16'h0);
                if (!lvl && s[0]) exp_n++;
                if (lvl && s[1]) exp_n++;
            end
            rd(5'd3, r); chk("R3 edge type count", r, 16'(exp_n));
        end
        wr(5'd0, 16'h0007); wr(5'd6, 16'h0005);
        toggle(16'hAAAA, 16'h5B5B);
        rd(5'd5, r); chk("R3 timebase B selected", r, 16'h5B5B);

        // R7: parameter capture mode
        wr(5'd21, 16'hBEEF); wr(5'd1, 16'h0005); wr(5'd6, 16'h0006);
        toggle(16'h1234, 16'h4321);
        rd(5'd5, r); chk("R7 parameter word captured", r, 16'hBEEF);

        // R1: no-op commands
        toggle(16'h0, 16'h0); toggle(16'h0, 16'h0);
        wr(5'd6, 16'h0004);
        rd(5'd3, r); chk("R1 command 00 keeps count", r, 16'h3);
        wr(5'd6, 16'h0007);
        rd(5'd3, r); chk("R1 command 11 keeps count", r, 16'h3);
        rd(5'd6, r); chk("R1 sequence bits updated", r, 16'h0004);

        // R2: initialization discards a pending edge
        pin_in = ~pin_in;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr(5'd6, 16'h0005);
        repeat (4) @(negedge clk);
        rd(5'd3, r); chk("R2 init discards pending edge", r, 16'h0);

        // R8: group size saturates at eight, zero sends nothing
        wr(5'd1, 16'h4C00); wr(5'd2, 16'h1); wr(5'd6, 16'h000D);
        link_pulses = 0; link_seen = '0;
        toggle(16'h0, 16'h0);
        chk("R8 link count clamps to 8", link_seen, 16'h0FF0);
        wr(5'd1, 16'h4000); wr(5'd6, 16'h000D);
        link_pulses = 0;
        toggle(16'h0, 16'h0);
        chk("R8 zero group no pulse", 16'(link_pulses), 16'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule